// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches an 8-bit input port, already synchronised to the core clock, and raises an interrupt when an enabled pin changes. Each pin has its own compare mode. In one mode a pin is compared with its value in the preceding cycle. In the other it is compared with a programmable default bit. When the first change is seen, the block freezes the port value in a capture register and marks the responsible pins in a flag register. The interrupt then stays pending until software reads either the capture register or the port register. The bus front end turns those reads into single-cycle pulses on `rd_cap_i` and `rd_port_i`.

Configuration arrives as single-cycle register writes. The flag and capture registers are read-only and are presented directly on output ports. The interrupt output is active low. A configuration bit selects whether the pad driver is push-pull, which always drives, or open-drain, which drives low only while an interrupt is pending and otherwise floats.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, `flag_o` and `cap_o` are 0, no interrupt is pending, `irq_o` is 1 and `irq_oe_o` is 1. All configuration registers are 0, so every pin is disabled, compares against its previous value, and the output is push-pull.
- R2: A pin whose enable bit is 0 never raises an interrupt, whatever its value does.
- R3: A pin whose enable bit is 1 and whose compare-mode bit is 0 raises an interrupt when, with nothing pending, its value differs from its value in the preceding cycle. The interrupt is pending from the next clock edge.
- R4: A pin whose enable bit is 1 and whose compare-mode bit is 1 raises an interrupt while its value differs from its default bit.
- R5: At the edge that makes an interrupt pending, `flag_o` takes exactly the set of enabled pins that caused it. A write to the flag address has no effect on `flag_o`.
- R6: At the edge that makes an interrupt pending, `cap_o` takes the port value. It changes at no other time, and it keeps its value after the interrupt is cleared.
- R7: While an interrupt is pending, further pin activity changes neither `flag_o` nor `cap_o`.
- R8: A pulse on `rd_cap_i` or on `rd_port_i` while an interrupt is pending clears the interrupt and `flag_o` at the next edge.
- R9: In default-compare mode, a pin that still differs from its default after the clearing read raises the interrupt again one edge after the clear.
- R10: In previous-value mode, the reference value is held while an interrupt is pending. A pin that ends up different from its value at interrupt time re-raises the interrupt one edge after the clear. A pin that returns to that value does not.
- R11: With configuration bit 0 equal to 0 (push-pull), `irq_oe_o` is 1 and `irq_o` is the inverse of the pending state. With that bit equal to 1 (open-drain), `irq_o` is 0 and `irq_oe_o` equals the pending state.
- R12: Register addresses on `wr_addr_i` are: 0 for the enable mask, 1 for compare mode, 2 for default values, 3 for configuration, and 4 for the flag register, which is read-only. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8 | Synchronised port value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_cap_i | input | 1 | Pulse: capture register was read |
| rd_port_i | input | 1 | Pulse: port register was read |
| flag_o | output | 8 | Pins that caused the pending interrupt |
| cap_o | output | 8 | Port value frozen at interrupt time |
| irq_o | output | 1 | Interrupt pad data, active low |
| irq_oe_o | output | 1 | Interrupt pad output enable |

## Verification
A register write takes effect at its own edge. An interrupt caused by a pin change therefore becomes pending, with flags and capture loaded, at the first edge after the change is applied. A clearing read removes the pending state at the edge that samples the pulse. A persistent default mismatch, or a reference mismatch left over from the pending period, re-raises the interrupt at the edge after that. The pad outputs are combinational from the pending state and the drive-mode bit, so they follow in the same cycle. The bench changes inputs one time unit after a rising edge and reads outputs at that same point, after exactly the number of edges listed above.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE  = 3'd0,
    SEL_MODE    = 3'd1,
    SEL_DEFAULT = 3'd2,
    SEL_CONFIG  = 3'd3,
    SEL_FLAG    = 3'd4
  } reg_sel_e;

  localparam int unsigned CFG_OD_BIT = 0;
endpackage

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
  import pin_irq_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  mode_o,
  output logic [WIDTH-1:0]  def_o,
  output logic              od_o
);
  logic [WIDTH-1:0] en_q, mode_q, def_q;
  logic             od_q;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
      def_q  <= '0;
      od_q   <= 1'b0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_ENABLE:  en_q   <= wr_data_i;
        SEL_MODE:    mode_q <= wr_data_i;
        SEL_DEFAULT: def_q  <= wr_data_i;
        SEL_CONFIG:  od_q   <= wr_data_i[CFG_OD_BIT];
        default:     ;  // flag register is read-only, other addresses unused
      endcase
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign def_o  = def_q;
  assign od_o   = od_q;

  AST_CFG_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q) && $stable(mode_q) && $stable(def_q) && $stable(od_q)); // R12
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] def_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] ref_q;
  logic [WIDTH-1:0] diff;

  // Reference follows the port except while an interrupt is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ref_q <= '0;
    else if (!hold_i) ref_q <= port_i;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    assign diff[g]  = mode_i[g] ? (port_i[g] ^ def_i[g]) : (port_i[g] ^ ref_q[g]);
    assign hit_o[g] = en_i[g] & diff[g];
  end

  AST_REF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(ref_q)); // R10
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & ~en_i) == '0); // R2
endmodule

// File: rtl/pin_irq_capture.sv
module pin_irq_capture #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] hit_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [WIDTH-1:0] flag_o,
  output logic [WIDTH-1:0] cap_o
);
  logic             pend_q;
  logic [WIDTH-1:0] flag_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
    end else if (pend_q) begin
      if (clr_i) begin
        pend_q <= 1'b0;
        flag_q <= '0;
      end
    end else if (|hit_i) begin
      pend_q <= 1'b1;
      flag_q <= hit_i;
      cap_q  <= port_i;
    end
  end

  assign pend_o = pend_q;
  assign flag_o = flag_q;
  assign cap_o  = cap_q;

  AST_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && (hit_i != '0) |=> pend_q && (flag_q == $past(hit_i))); // R3
  AST_PEND_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> flag_q != '0); // R5
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> $stable(cap_q)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q && $stable(flag_q)); // R7
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && clr_i |=> !pend_q && (flag_q == '0)); // R8
endmodule

// File: rtl/pin_irq_drive.sv
module pin_irq_drive (
  input  logic pend_i,
  input  logic od_i,
  output logic irq_o,
  output logic irq_oe_o
);
  always_comb begin
    if (od_i) begin
      irq_o    = 1'b0;
      irq_oe_o = pend_i;
    end else begin
      irq_o    = ~pend_i;
      irq_oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  port_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic              rd_cap_i,
  input  logic              rd_port_i,
  output logic [WIDTH-1:0]  flag_o,
  output logic [WIDTH-1:0]  cap_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  logic [WIDTH-1:0] en, mode, dflt, hit;
  logic             od, pend, clr;

  assign clr = rd_cap_i | rd_port_i;

  pin_irq_cfg #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .mode_o(mode), .def_o(dflt), .od_o(od)
  );

  pin_irq_detect #(.WIDTH(WIDTH)) i_detect (
    .clk_i, .rst_ni, .port_i, .en_i(en), .mode_i(mode), .def_i(dflt),
    .hold_i(pend), .hit_o(hit)
  );

  pin_irq_capture #(.WIDTH(WIDTH)) i_capture (
    .clk_i, .rst_ni, .port_i, .hit_i(hit), .clr_i(clr),
    .pend_o(pend), .flag_o, .cap_o
  );

  pin_irq_drive i_drive (
    .pend_i(pend), .od_i(od), .irq_o, .irq_oe_o
  );

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od |-> !irq_o && (irq_oe_o == pend)); // R11
  AST_PP_ALWAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !od |-> irq_oe_o && (irq_o == !pend)); // R11
  AST_DEFAULT_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend && ((en & mode & (port_i ^ dflt)) != '0) |=> pend); // R4 R9
endmodule

// File: tb/test_pin_irq_ctrl.sv
`timescale 1ns/1ps
module test_pin_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port = 8'h00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_cap = 1'b0, rd_port = 1'b0;
  logic [7:0] flag, cap;
  logic       irq, irq_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_cap_i(rd_cap),
    .rd_port_i(rd_port), .flag_o(flag), .cap_o(cap), .irq_o(irq),
    .irq_oe_o(irq_oe)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic read_cap();
    rd_cap = 1'b1; tick(); rd_cap = 1'b0;
  endtask

  task automatic read_port();
    rd_port = 1'b1; tick(); rd_port = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "flag", flag, 8'h00);
    chk("R1", "cap", cap, 8'h00);
    chk("R1", "irq", {7'd0, irq}, 8'h01);
    chk("R1", "oe", {7'd0, irq_oe}, 8'h01);
  endtask

  task automatic t_disabled();
    port = 8'hA5; tick();
    port = 8'h5A; tick();
    port = 8'hFF; tick(); tick();
    chk("R2", "irq", {7'd0, irq}, 8'h01);
    chk("R2", "flag", flag, 8'h00);
  endtask

  task automatic t_prev();
    wr(3'd0, 8'hFF);            // R12 enable address
    tick();
    chk("R3", "no irq idle", {7'd0, irq}, 8'h01);
    port = 8'hFA; tick();       // bits 0 and 2 drop
    chk("R3", "irq", {7'd0, irq}, 8'h00);
    chk("R5", "flag", flag, 8'h05);
    chk("R6", "cap", cap, 8'hFA);
    port = 8'hF2; tick();       // bit 3 drops while pending
    chk("R7", "flag held", flag, 8'h05);
    chk("R7", "cap held", cap, 8'hFA);
    wr(3'd4, 8'hFF);
    chk("R5", "flag write ignored", flag, 8'h05);
    read_cap();
    chk("R8", "irq cleared", {7'd0, irq}, 8'h01);
    chk("R8", "flag cleared", flag, 8'h00);
    chk("R6", "cap kept", cap, 8'hFA);
    tick();                     // reference still FA, port F2
    chk("R10", "refire", {7'd0, irq}, 8'h00);
    chk("R10", "refire flag", flag, 8'h08);
    chk("R10", "refire cap", cap, 8'hF2);
    port = 8'hF3; tick();
    port = 8'hF2; tick();       // returns to value at interrupt time
    read_port();
    chk("R8", "port read clears", {7'd0, irq}, 8'h01);
    tick();
    chk("R10", "no refire", {7'd0, irq}, 8'h01);
    chk("R10", "no refire flag", flag, 8'h00);
  endtask

  task automatic t_default();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'hF2);
    wr(3'd0, 8'h80);
    tick();
    chk("R4", "match quiet", {7'd0, irq}, 8'h01);
    port = 8'h72; tick();
    chk("R4", "irq", {7'd0, irq}, 8'h00);
    chk("R4", "flag", flag, 8'h80);
    chk("R6", "cap", cap, 8'h72);
    read_cap();
    chk("R8", "cleared", {7'd0, irq}, 8'h01);
    tick();
    chk("R9", "refire", {7'd0, irq}, 8'h00);
    chk("R9", "refire flag", flag, 8'h80);
    port = 8'hF2; tick();
    read_port(); tick(); tick();
    chk("R9", "quiet after match", {7'd0, irq}, 8'h01);
    wr(3'd6, 8'hFF);            // unused address
    port = 8'h00; tick();
    chk("R12", "unused addr", {7'd0, irq}, 8'h00);
    chk("R12", "unused addr flag", flag, 8'h80);
    port = 8'hF2; read_cap(); tick();
  endtask

  task automatic t_drive();
    wr(3'd3, 8'h01);
    chk("R11", "od idle oe", {7'd0, irq_oe}, 8'h00);
    chk("R11", "od idle data", {7'd0, irq}, 8'h00);
    port = 8'h72; tick();
    chk("R11", "od pend oe", {7'd0, irq_oe}, 8'h01);
    chk("R11", "od pend data", {7'd0, irq}, 8'h00);
    read_cap();
    chk("R11", "od clear oe", {7'd0, irq_oe}, 8'h00);
    wr(3'd3, 8'h00);            // pending again from persistent mismatch
    chk("R11", "pp oe", {7'd0, irq_oe}, 8'h01);
    chk("R11", "pp data", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_prev();
    t_default();
    t_drive();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule